// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked front-end for an external asynchronous static RAM of 64K words by 16 bits with separate enables for the upper and lower byte. A host hands it one transaction at a time over a valid/ready handshake: an address, a two-bit byte mask, write data and a read/write flag. The controller then drives chip select, write enable, output enable, the byte enables, the address and the data bus (as separate output data, output-enable and input data) through a fixed sequence of states. Each state lasts a parameterised number of clock cycles, so address setup, write pulse width, data setup and hold, access time and bus turnaround are all met by counting.

Writes are qualified per byte lane: only lanes whose mask bit is set get a low byte enable. When the design is built to keep output enable low through a write, the write pulse is lengthened to cover the memory's output-release time plus the data setup time. Chip select and the byte enables always fall ahead of write enable, so this lengthening is needed. The controller drives the bus only during the data-setup window and the data hold that follows it. Reads return the enabled lanes in a capture register with a one-clock valid pulse, followed by a turnaround gap. A transaction with an empty mask completes without any memory cycle.

Top module: `asram_lane_ctl`

## Requirements
- R1: After synchronous reset and whenever `req_ready` is high, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11 and `mem_dq_oe` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the edge after a non-empty request is taken until its memory cycle ends. A request presented while `req_ready` is low has no effect.
- R3: Mask bit 1 selects data bits 15:8 and drives `mem_be_n[1]`. Mask bit 0 selects bits 7:0 and drives `mem_be_n[0]`. Throughout a memory cycle `mem_be_n` equals the inverted mask and `mem_addr` equals the request address.
- R4: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for exactly T_ACCESS cycles. It then latches `mem_dq_i` into `rd_data` and raises `rd_valid` for one clock. Lanes whose mask bit is 0 read back as zero.
- R5: After a read's chip-select period, `mem_cs_n` and `mem_oe_n` stay high with `req_ready` low for exactly T_TURN cycles, counted from the `rd_valid` cycle.
- R6: A write first holds `mem_cs_n` and the selected byte enables low with `mem_we_n` high for T_ADDR_SETUP cycles. It then pulls `mem_we_n` low. `mem_we_n` is low only while `mem_cs_n` is low and at least one byte enable is low.
- R7: `mem_we_n` stays low for T_WE_PULSE cycles when OE_IN_WRITE is 0. When OE_IN_WRITE is 1 it stays low for max(T_WE_PULSE, T_OE_RELEASE + T_DATA_SETUP) cycles, and `mem_oe_n` is then low during the setup and pulse.
- R8: `mem_dq_oe` is high only during the last T_DATA_SETUP cycles of the write pulse and the T_DATA_HOLD cycles after `mem_we_n` rises. `mem_oe_n` is high from the cycle `mem_we_n` rises.
- R9: A request with mask 2'b00 starts no memory cycle and `req_ready` stays high. For a write it changes no memory contents. For a read it gives `rd_valid` on the next clock with `rd_data` equal to 0.
- R10: While `mem_cs_n` stays low, `mem_addr` and `mem_be_n` do not change. `mem_dq_oe` is never high while the memory could be driving the bus (chip select and output enable low, write enable high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_mask | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-clock pulse marking `rd_data` valid |
| rd_data | output | 16 | Read result, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 1 upper |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The assertions assume that every timing parameter is at least one and that T_WE_PULSE is not below T_DATA_SETUP; an elaboration-time check enforces both. They also assume reset is held for at least one clock before the first request. They take for granted that the memory drives `mem_dq_i` only while chip select and output enable are low with write enable high. The bench's memory model follows that rule and merges written lanes at the rising edge of write enable. The bench changes host inputs only on falling clock edges, waits for `req_ready` before presenting a request, and uses addresses whose low ten bits are distinct so its small model array never aliases.

// File: rtl/asram_lane_pkg.sv
// Shared types for the asynchronous SRAM byte-lane controller.
// Assumes: nothing beyond a standard SystemVerilog tool.
package asram_lane_pkg;

    // Sequencer phases of one memory transaction
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_TURN     = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } lane_state_t;

    // Larger of two cycle counts, used to size the stretched write pulse
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_step_timer.sv
// Down-counter that times the length of each sequencer phase.
// Loading N makes last high in the N-th cycle after the load.
// Assumes: the loaded value is never zero.
module asram_step_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          last
);

    // Load a new phase length or count down toward one
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CW'(1);
        else if (load)
            count <= load_val;
        else if (count > CW'(1))
            count <= count - CW'(1);
    end

    // Final cycle of the current phase
    always_comb last = (count == CW'(1));

    // A zero-length phase would never reach last
    p_load_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/asram_lane_seq.sv
// Transaction sequencer: owns the state register, takes host requests
// only in idle, and loads the phase timer on every state change.
// Assumes: timing values are at least one cycle.
module asram_lane_seq
    import asram_lane_pkg::*;
#(
    parameter int CW         = 4,
    parameter int T_SETUP    = 1,
    parameter int T_PULSE    = 2,
    parameter int T_HOLD     = 1,
    parameter int T_ACCESS   = 3,
    parameter int T_TURN     = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_nonzero,
    input  logic          tmr_last,
    output lane_state_t   state,
    output logic          req_ready,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          rd_strobe,
    output logic          zero_rd
);

    lane_state_t nxt;
    logic        take;

    // Handshake: only the idle state accepts work
    always_comb begin
        req_ready = (state == ST_IDLE);
        take      = req_valid && req_ready;
        zero_rd   = take && !req_write && !req_nonzero;
        rd_strobe = (state == ST_RD_ACC) && tmr_last;
    end

    // Next phase and the length to load for it
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = CW'(1);
        case (state)
            ST_IDLE: if (take && req_nonzero) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    nxt     = ST_WR_SETUP;
                    tmr_val = CW'(T_SETUP);
                end else begin
                    nxt     = ST_RD_ACC;
                    tmr_val = CW'(T_ACCESS);
                end
            end
            ST_RD_ACC: if (tmr_last) begin
                nxt = ST_TURN; tmr_load = 1'b1; tmr_val = CW'(T_TURN);
            end
            ST_TURN: if (tmr_last) nxt = ST_IDLE;
            ST_WR_SETUP: if (tmr_last) begin
                nxt = ST_WR_PULSE; tmr_load = 1'b1; tmr_val = CW'(T_PULSE);
            end
            ST_WR_PULSE: if (tmr_last) begin
                nxt = ST_WR_HOLD; tmr_load = 1'b1; tmr_val = CW'(T_HOLD);
            end
            ST_WR_HOLD: if (tmr_last) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // One outstanding transaction: a real cycle drops ready next clock
    p_single_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_nonzero) |=> !req_ready);

endmodule

// File: rtl/asram_rd_capture.sv
// Read capture register: keeps the enabled byte lanes of the memory
// bus at the end of the access time and flags them for one clock.
// Assumes: strobe and zero are never high together.
module asram_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              zero,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int LW = DATA_W / LANES;

    logic [DATA_W-1:0] masked;

    // Per-lane gate: a disabled lane contributes zeros
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LW +: LW] = lane_en[g] ? dq_i[g*LW +: LW] : '0;
    end

    // Capture on strobe, return zero for an empty-mask read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= strobe || zero;
            if (strobe)    rd_data <= masked;
            else if (zero) rd_data <= '0;
        end
    end

endmodule

// File: rtl/asram_lane_ctl.sv
// Top of the asynchronous SRAM byte-lane controller. Registers the
// accepted request, decodes the memory strobes from the sequencer
// state and drives write data only inside the setup/hold window.
// Assumes: every timing parameter >= 1 and T_WE_PULSE >= T_DATA_SETUP.
module asram_lane_ctl
    import asram_lane_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int T_ADDR_SETUP = 1,
    parameter int T_WE_PULSE   = 2,
    parameter int T_OE_RELEASE = 2,
    parameter int T_DATA_SETUP = 1,
    parameter int T_DATA_HOLD  = 1,
    parameter int T_ACCESS     = 3,
    parameter int T_TURN       = 1,
    parameter bit OE_IN_WRITE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W/8-1:0] req_mask,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int LANES = DATA_W / 8;
    localparam int PULSE = OE_IN_WRITE ? max2(T_WE_PULSE, T_OE_RELEASE + T_DATA_SETUP)
                                       : T_WE_PULSE;
    localparam int MAXT  = max2(max2(max2(T_ADDR_SETUP, PULSE), max2(T_DATA_HOLD, T_ACCESS)),
                                T_TURN);
    localparam int CW    = $clog2(MAXT + 1);

    lane_state_t       state;
    logic              tmr_load, tmr_last, rd_strobe, zero_rd, take_nz, cs_act;
    logic [CW-1:0]     tmr_val, tmr_count;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] wdata_q;

    // Parameter sanity at elaboration
    initial begin
        a_params_r7: assert (T_ADDR_SETUP >= 1 && T_WE_PULSE >= T_DATA_SETUP &&
                             T_DATA_SETUP >= 1 && T_DATA_HOLD >= 1 &&
                             T_ACCESS >= 1 && T_TURN >= 1);
    end

    asram_lane_seq #(
        .CW(CW), .T_SETUP(T_ADDR_SETUP), .T_PULSE(PULSE), .T_HOLD(T_DATA_HOLD),
        .T_ACCESS(T_ACCESS), .T_TURN(T_TURN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_nonzero(|req_mask), .tmr_last(tmr_last), .state(state),
        .req_ready(req_ready), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .rd_strobe(rd_strobe), .zero_rd(zero_rd)
    );

    asram_step_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .count(tmr_count), .last(tmr_last)
    );

    asram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
        .clk(clk), .rst_n(rst_n), .strobe(rd_strobe), .zero(zero_rd),
        .lane_en(mask_q), .dq_i(mem_dq_i), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Hold the accepted request for the length of its memory cycle
    always_comb take_nz = req_valid && req_ready && (|req_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
        end else if (take_nz) begin
            addr_q  <= req_addr;
            mask_q  <= req_mask;
            wdata_q <= req_wdata;
        end
    end

    // Strobe decode from the sequencer phase
    always_comb begin
        cs_act    = (state == ST_RD_ACC) || (state == ST_WR_SETUP) ||
                    (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
        mem_cs_n  = !cs_act;
        mem_we_n  = (state != ST_WR_PULSE);
        mem_oe_n  = !((state == ST_RD_ACC) ||
                      (OE_IN_WRITE && ((state == ST_WR_SETUP) || (state == ST_WR_PULSE))));
        mem_be_n  = cs_act ? ~mask_q : '1;
        mem_addr  = addr_q;
        mem_dq_o  = wdata_q;
        mem_dq_oe = ((state == ST_WR_PULSE) && (tmr_count <= CW'(T_DATA_SETUP))) ||
                    (state == ST_WR_HOLD);
    end

    // Idle leaves the memory deselected and the bus released
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    // Write strobe only inside the select/byte-enable overlap
    p_we_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && (mem_be_n != '1)));

    // Address and lanes frozen while selected
    p_pins_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    // No bus fight with a memory that may be driving
    p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n || !mem_we_n || mem_cs_n));

    // End of write: output enable off, data still held
    p_hold_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_oe_n && mem_dq_oe));

    // A captured read came from a cycle with write enable high
    p_read_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(!mem_cs_n)) |-> $past(mem_we_n));

    // Turnaround keeps the memory deselected
    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !req_ready) |-> (mem_cs_n && mem_oe_n));

endmodule

// File: tb/asram_lane_ctl_bench.sv
// Scoreboard bench: driver tasks push expected read words, a negedge
// monitor pops and compares them and measures strobe phase lengths.
module asram_lane_ctl_bench;

    localparam int T_AS = 2, T_WP = 3, T_OHZ = 3, T_DW = 2, T_DH = 1, T_AA = 4, T_TA = 2;
    localparam bit OEW  = 1'b1;
    localparam int PULSE = OEW ? ((T_WP > T_OHZ + T_DW) ? T_WP : T_OHZ + T_DW) : T_WP;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [15:0] rd_data, mem_addr, mem_dq_o, mem_dq_i;
    logic [1:0]  mem_be_n;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] model  [0:1023];
    logic [15:0] shadow [0:1023];
    logic [15:0] expq [$];

    always #5 clk = ~clk;

    asram_lane_ctl #(
        .T_ADDR_SETUP(T_AS), .T_WE_PULSE(T_WP), .T_OE_RELEASE(T_OHZ),
        .T_DATA_SETUP(T_DW), .T_DATA_HOLD(T_DH), .T_ACCESS(T_AA),
        .T_TURN(T_TA), .OE_IN_WRITE(OEW)
    ) u_asram_lane_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: drives only when selected, output-enabled, not writing
    always_comb begin
        if (!mem_cs_n && !mem_oe_n && mem_we_n)
            mem_dq_i = {mem_be_n[1] ? 8'hA5 : model[mem_addr[9:0]][15:8],
                        mem_be_n[0] ? 8'h5A : model[mem_addr[9:0]][7:0]};
        else
            mem_dq_i = 16'hDEAD;
    end

    // Monitor: model writes, scoreboard, phase-length measurement
    logic prev_we = 1'b1, prev_cs = 1'b1, saw_we = 1'b0, hold_on = 1'b0, turn_on = 1'b0;
    int cs_run = 0, we_run = 0, drv_pulse = 0, hold_run = 0, turn_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n && mem_we_n && !mem_cs_n)
                check(1'b0, "R10 bus contention", 1, 0);
            // write lands at write-enable rise
            if (!prev_we && mem_we_n) begin
                check(mem_dq_oe == 1'b1, "R8 data at WE rise", mem_dq_oe, 1);
                check(mem_oe_n == 1'b1, "R8 OE high at WE rise", mem_oe_n, 1);
                check(we_run == PULSE, "R7 write pulse length", we_run, PULSE);
                check(drv_pulse == T_DW, "R8 drive cycles in pulse", drv_pulse, T_DW);
                if (!mem_be_n[1]) model[mem_addr[9:0]][15:8] = mem_dq_o[15:8];
                if (!mem_be_n[0]) model[mem_addr[9:0]][7:0]  = mem_dq_o[7:0];
                we_run = 0; drv_pulse = 0; hold_on = 1'b1; hold_run = 0;
            end
            if (!mem_we_n) begin
                check(!mem_cs_n && mem_be_n != 2'b11, "R6 WE inside overlap", mem_be_n, 0);
                we_run++;
                if (mem_dq_oe) drv_pulse++;
            end
            if (hold_on) begin
                if (mem_dq_oe) hold_run++;
                else begin
                    check(hold_run == T_DH, "R8 data hold cycles", hold_run, T_DH);
                    hold_on = 1'b0;
                end
            end
            // chip-select phase lengths
            if (!mem_cs_n) begin
                if (!mem_we_n && prev_we && !saw_we) begin
                    check(cs_run == T_AS, "R6 address setup", cs_run, T_AS);
                    saw_we = 1'b1;
                end
                if (mem_we_n && !saw_we) cs_run++;
                if (!prev_cs)
                    check(1'b1, "R10", 0, 0);
            end else if (!prev_cs) begin
                if (!saw_we) check(cs_run == T_AA, "R4 access length", cs_run, T_AA);
                cs_run = 0; saw_we = 1'b0;
            end
            // turnaround after a read
            if (turn_on) begin
                if (req_ready) begin
                    check(turn_run == T_TA, "R5 turnaround length", turn_run, T_TA);
                    turn_on = 1'b0;
                end else begin
                    check(mem_cs_n && mem_oe_n, "R5 deselected in turnaround", mem_cs_n, 1);
                    turn_run++;
                end
            end
            // scoreboard
            if (rd_valid) begin
                if (expq.size() == 0) check(1'b0, "R4 unexpected rd_valid", 1, 0);
                else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    check(rd_data == e, "R4 R3 read data", rd_data, e);
                end
                if (!req_ready) begin turn_on = 1'b1; turn_run = 1; end
            end
        end
        prev_we = mem_we_n;
        prev_cs = mem_cs_n;
    end

    // Driver: one host transaction, expected read pushed at issue
    task automatic host_op(input bit wr, input logic [15:0] a, input logic [1:0] m,
                           input logic [15:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
        if (!wr)
            expq.push_back({m[1] ? shadow[a[9:0]][15:8] : 8'h00,
                            m[0] ? shadow[a[9:0]][7:0]  : 8'h00});
        else begin
            if (m[1]) shadow[a[9:0]][15:8] = d[15:8];
            if (m[0]) shadow[a[9:0]][7:0]  = d[7:0];
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 2'b00) begin
            check(mem_cs_n == 1'b1, "R9 empty mask no cycle", mem_cs_n, 1);
            check(req_ready == 1'b1, "R9 ready stays high", req_ready, 1);
        end else begin
            check(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
            check(mem_be_n == ~m, "R3 byte enables", mem_be_n, ~m);
            check(mem_addr == a, "R3 address", mem_addr, a);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            model[i]  = 16'(i * 16'h0131 + 16'h0F0F);
            shadow[i] = 16'(i * 16'h0131 + 16'h0F0F);
        end
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset", mem_cs_n, 1);
        check(mem_be_n == 2'b11 && !mem_dq_oe, "R1 lanes and bus in reset", mem_be_n, 3);
        check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;

        host_op(1'b0, 16'h1010, 2'b11, 16'h0);   // plain read
        host_op(1'b1, 16'h2011, 2'b11, 16'hBEEF);
        host_op(1'b0, 16'h2011, 2'b11, 16'h0);
        host_op(1'b1, 16'h3012, 2'b10, 16'hC3A1); // upper lane only
        host_op(1'b0, 16'h3012, 2'b11, 16'h0);
        host_op(1'b1, 16'h4013, 2'b01, 16'h77E4); // lower lane only
        host_op(1'b0, 16'h4013, 2'b11, 16'h0);
        host_op(1'b0, 16'h4013, 2'b10, 16'h0);    // masked read, lower zero
        host_op(1'b0, 16'h3012, 2'b01, 16'h0);    // masked read, upper zero
        host_op(1'b1, 16'h5014, 2'b00, 16'h1234); // R9 empty write
        host_op(1'b0, 16'h5014, 2'b11, 16'h0);
        host_op(1'b0, 16'h5014, 2'b00, 16'h0);    // R9 empty read -> 0
        host_op(1'b1, 16'h6015, 2'b11, 16'h0001);
        host_op(1'b1, 16'h6015, 2'b11, 16'hFFFE); // back-to-back writes
        host_op(1'b0, 16'h6015, 2'b11, 16'h0);

        // R2: a write held valid during a busy read is never taken
        host_op(1'b0, 16'h7016, 2'b11, 16'h0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h7017;
        req_mask = 2'b11; req_wdata = 16'hBAD0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b0;
        host_op(1'b0, 16'h7017, 2'b11, 16'h0);    // R2 expects old contents

        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R4 all reads returned", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog R2", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule